// File: doc/BRIEF.md
# Sleep Mode Controller with Link Wake

This block sets the power state of a network device's core and its receive front end. A low-active sleep request sends the block into one of two low-power states. Which one depends on a configuration bit, captured at the moment sleep begins.

- **Deep state:** the core and the receive path are both shut down. Link monitoring stops, and nothing inside the block can end the state.
- **Light state:** the core is shut down, but the receive path stays powered and link monitoring keeps running. The link indicator keeps working, so board logic can watch it and release the sleep request when traffic or link pulses appear.

Link monitoring is a retriggerable timeout. A link-pulse strobe or a frame-valid strobe lights the active-low link LED. The LED stays lit for a window of `LINK_WINDOW` clock cycles after the last strobe. The default window is 5,000,000 cycles, which is 50 ms at 100 MHz.

There is no data stream through the block, so all pins are plain level or strobe signals. There is no valid/ready handshake and no back-pressure.

Top module: `lpwr_link_wake`

## Requirements
- R1: After reset, `pwr_mode` is ACTIVE (2'b00), `core_en` and `rx_en` are 1, and `link_led_n` is 1 (unlit).
- R2: `sleep_n` is sampled low in ACTIVE with `light_sel`=0. From the next cycle, `pwr_mode` is DEEP (2'b10) and `core_en`=`rx_en`=0.
- R3: `sleep_n` is sampled low in ACTIVE with `light_sel`=1. From the next cycle, `pwr_mode` is LIGHT (2'b01), `core_en`=0 and `rx_en`=1.
- R4: In DEEP, `link_led_n` is 1 and strobes are ignored. After a wake, the LED stays unlit until a new strobe arrives.
- R5: DEEP persists for as long as `sleep_n` stays low, whatever strobes arrive.
- R6: In LIGHT, a strobe on `link_pulse` or `frame_ok` drives `link_led_n` low from the next cycle.
- R7: `link_led_n` stays low for exactly `LINK_WINDOW` cycles after the last strobe, then returns to 1. Each new strobe restarts the window.
- R8: `sleep_n` sampled high returns the block to ACTIVE on the next cycle, with `core_en`=`rx_en`=1.
- R9: Changing `light_sel` while asleep has no effect on `pwr_mode` until the next sleep entry.
- R10: In ACTIVE, strobes light the LED exactly as in LIGHT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_n | input | 1 | Sleep request, active low |
| light_sel | input | 1 | 1 selects the light state, 0 the deep state |
| link_pulse | input | 1 | One-cycle strobe: link pulse detected |
| frame_ok | input | 1 | One-cycle strobe: valid frame received |
| rx_en | output | 1 | Receive path enable |
| core_en | output | 1 | Core enable |
| link_led_n | output | 1 | Link indicator, active low |
| pwr_mode | output | 2 | 00 ACTIVE, 01 LIGHT, 10 DEEP |

## Verification
The hardest situation to reach is a lit LED whose window is cut short by a deep-state entry. The bench lights the LED in ACTIVE and, well inside the window, asserts sleep with `light_sel` low. It then fires strobes during DEEP and releases sleep. At that point the LED must be unlit, which shows the remaining window was discarded rather than frozen. The bench also flips `light_sel` mid-sleep to confirm the state captured at entry holds. It uses a short window so that expiry and retrigger can be checked at the exact cycle.

// File: rtl/lpwr_pkg.sv
package lpwr_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_LIGHT  = 2'b01,
    PM_DEEP   = 2'b10
  } pm_state_e;
endpackage

// File: rtl/lpwr_state_fsm.sv
module lpwr_state_fsm
  import lpwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_n,
  input  logic      light_sel,
  output pm_state_e state_q
);
  pm_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (sleep_n) begin
      state_d = PM_ACTIVE;
    end else if (state_q == PM_ACTIVE) begin
      // depth chosen only at entry; held until wake
      state_d = light_sel ? PM_LIGHT : PM_DEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_ACTIVE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/lpwr_link_timer.sv
module lpwr_link_timer #(
  parameter int unsigned LINK_WINDOW = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_en,
  input  logic hit,
  output logic link_up
);
  localparam int unsigned CW = $clog2(LINK_WINDOW + 1);
  localparam logic [CW-1:0] LOAD = CW'(LINK_WINDOW);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (!mon_en) begin
      remain_q <= '0;
    end else if (hit) begin
      remain_q <= LOAD;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign link_up = (remain_q != '0);
endmodule

// File: rtl/lpwr_link_wake.sv
module lpwr_link_wake
  import lpwr_pkg::*;
#(
  parameter int unsigned LINK_WINDOW = 5_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_n,
  input  logic       light_sel,
  input  logic       link_pulse,
  input  logic       frame_ok,
  output logic       rx_en,
  output logic       core_en,
  output logic       link_led_n,
  output logic [1:0] pwr_mode
);
  pm_state_e state_q;
  logic      in_deep;
  logic      link_up;

  lpwr_state_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_n  (sleep_n),
    .light_sel(light_sel),
    .state_q  (state_q)
  );

  assign in_deep = (state_q == PM_DEEP);

  lpwr_link_timer #(.LINK_WINDOW(LINK_WINDOW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .mon_en (!in_deep),
    .hit    (link_pulse | frame_ok),
    .link_up(link_up)
  );

  assign core_en    = (state_q == PM_ACTIVE);
  assign rx_en      = !in_deep;
  assign link_led_n = in_deep | !link_up;
  assign pwr_mode   = state_q;
endmodule

// File: rtl/lpwr_link_wake_chk.sv
module lpwr_link_wake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_n,
  input logic       light_sel,
  input logic       link_pulse,
  input logic       frame_ok,
  input logic       rx_en,
  input logic       core_en,
  input logic       link_led_n,
  input logic [1:0] pwr_mode
);
  p_deep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b00 && !sleep_n && !light_sel) |=> (pwr_mode == 2'b10 && !core_en && !rx_en));

  p_light_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b00 && !sleep_n && light_sel) |=> (pwr_mode == 2'b01 && !core_en && rx_en));

  p_deep_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b10) |-> (link_led_n && !rx_en));

  p_no_self_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b10 && !sleep_n) |=> (pwr_mode == 2'b10));

  p_light_led_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b01 && !sleep_n && (link_pulse || frame_ok)) |=> !link_led_n);

  p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_n |=> (pwr_mode == 2'b00 && core_en && rx_en));

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode != 2'b00 && !sleep_n) |=> $stable(pwr_mode));
endmodule

bind lpwr_link_wake lpwr_link_wake_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep_n   (sleep_n),
  .light_sel (light_sel),
  .link_pulse(link_pulse),
  .frame_ok  (frame_ok),
  .rx_en     (rx_en),
  .core_en   (core_en),
  .link_led_n(link_led_n),
  .pwr_mode  (pwr_mode)
);

// File: tb/test_lpwr_link_wake.sv
`timescale 1ns/1ps
module test_lpwr_link_wake;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_n = 1'b1, light_sel = 1'b0, link_pulse = 1'b0, frame_ok = 1'b0;
  logic rx_en, core_en, link_led_n;
  logic [1:0] pwr_mode;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  typedef struct {
    logic [1:0] mode;
    logic core;
    logic rx;
    logic led_n;
    string req;
  } exp_t;
  exp_t sb[$];

  // expected-behaviour model state
  logic [1:0] m_mode = 2'b00;
  int m_win = 0;

  always #5 clk = ~clk;

  lpwr_link_wake #(.LINK_WINDOW(W)) i_lpwr_link_wake (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .light_sel(light_sel),
    .link_pulse(link_pulse), .frame_ok(frame_ok), .rx_en(rx_en),
    .core_en(core_en), .link_led_n(link_led_n), .pwr_mode(pwr_mode)
  );

  // monitor: compares design outputs after each edge
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      tests++;
      if (pwr_mode !== e.mode || core_en !== e.core || rx_en !== e.rx || link_led_n !== e.led_n) begin
        fails++;
        $display("FAIL %s: got mode=%b core=%b rx=%b led_n=%b exp mode=%b core=%b rx=%b led_n=%b",
                 e.req, pwr_mode, core_en, rx_en, link_led_n, e.mode, e.core, e.rx, e.led_n);
      end
    end
  end

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input logic sl, input logic ls, input logic lp, input logic fv, input string req);
    exp_t e;
    @(negedge clk); #1;
    sleep_n = sl; light_sel = ls; link_pulse = lp; frame_ok = fv;
    if (m_mode == 2'b10) m_win = 0;
    else if (lp || fv) m_win = W;
    else if (m_win > 0) m_win--;
    if (sl) m_mode = 2'b00;
    else if (m_mode == 2'b00) m_mode = ls ? 2'b01 : 2'b10;
    e.mode  = m_mode;
    e.core  = (m_mode == 2'b00);
    e.rx    = (m_mode != 2'b10);
    e.led_n = (m_mode == 2'b10) || (m_win == 0);
    e.req   = req;
    sb.push_back(e);
  endtask

  task automatic idle(input int n, input logic sl, input logic ls, input string req);
    for (int i = 0; i < n; i++) step(sl, ls, 1'b0, 1'b0, req);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got hang exp completion");
    done = 1;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tests++;
    if (pwr_mode !== 2'b00 || core_en !== 1'b1 || rx_en !== 1'b1 || link_led_n !== 1'b1) begin
      fails++;
      $display("FAIL R1: got mode=%b core=%b rx=%b led_n=%b exp 00 1 1 1", pwr_mode, core_en, rx_en, link_led_n);
    end
    rst_n = 1'b1;
    idle(2, 1, 0, "R1");
    // R10 / R7: active-mode LED, exact window, retrigger
    step(1, 0, 1, 0, "R10");
    idle(W - 1, 1, 0, "R7");
    idle(2, 1, 0, "R7 expiry");
    step(1, 0, 0, 1, "R10 frame");
    idle(5, 1, 0, "R7");
    step(1, 0, 1, 0, "R7 retrigger");
    idle(W + 2, 1, 0, "R7");
    // R2 / R4 / R5 / R9: deep state
    step(1, 0, 1, 0, "R10 lit before deep");
    idle(3, 1, 0, "R10");
    step(0, 0, 0, 0, "R2 deep entry");
    step(0, 0, 1, 0, "R4 pulse ignored");
    step(0, 1, 0, 1, "R9 cfg flip deep");
    step(0, 1, 1, 1, "R5 no self-wake");
    idle(4, 0, 1, "R5");
    step(1, 1, 0, 0, "R8 wake from deep");
    idle(3, 1, 1, "R4 led stays off");
    // R3 / R6 / R9 / R7: light state
    step(0, 1, 0, 0, "R3 light entry");
    idle(2, 0, 0, "R3");
    step(0, 0, 0, 1, "R6 frame in light");
    step(0, 0, 0, 0, "R9 cfg flip light");
    idle(W, 0, 0, "R7 light window");
    step(0, 0, 1, 0, "R6 pulse in light");
    idle(3, 0, 1, "R9");
    step(1, 0, 0, 0, "R8 wake from light");
    idle(W, 1, 0, "R7");
    idle(2, 1, 0, "R8");
    done = 1;
  end

  initial begin
    wait (done);
    @(negedge clk); @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule